// File: doc/BRIEF.md
# Audio and Auxiliary-Bit TDM Serializer

This block takes stereo audio samples recovered by an S/PDIF receiver, along with the auxiliary bits for each channel (channel status, user data and validity), and sends them out serially. The block's clock is the bit clock, so each clock cycle carries exactly one serial bit.

The block has two output formats. In I2S it produces a plain stereo stream: a word-select line and a data line. In TDM it produces an eight-slot frame. That frame carries the left sample, the right sample and a packed word of decoded bits. The decoded-bit word always belongs to the same sample pair as the audio in that frame. A frame counter runs modulo the length of a channel-status block and generates a block-start flag. That flag goes out in the packed word and on a separate auxiliary output group.

A small configuration register selects the format and enables the two output groups independently. A single-cycle write port stands in for the host interface. The receiver presents a new sample pair with a one-cycle strobe. That pair is applied only at the next frame boundary.

Top module: `aux_tdm_serializer`

## Requirements
- R1: While reset is asserted and directly after it, the configuration is zero and every output is low.
- R2: A configuration write stores data bits 2 (format: 1 = TDM, 0 = I2S), 1 (auxiliary group enable) and 0 (audio group enable), and ignores bits 15:3. Every write restarts the frame at bit 0 on the following cycle and counts as a frame boundary.
- R3: In TDM a frame is 256 clocks: eight 32-clock slots, numbered 0 to 7 in transmit order. The frame-sync output is high for exactly the first clock of slot 0.
- R4: In TDM the 24-bit left sample goes in slot 0 and the right sample in slot 4, MSB first, in the first 24 clocks of the slot. The rest of those slots and all of slots 2, 3, 5, 6 and 7 are 0.
- R5: In TDM, slot 1 carries seven bits in its first seven clocks, in this order: block start, right status, left status, right user, left user, right validity, left validity. The remaining 25 clocks are 0.
- R6: In I2S a frame is 64 clocks. The word-select output is low for the first 32 clocks (left) and high for the last 32 (right). Each sample's MSB is sent in the second clock of its half, and the 24 bits are followed by zeros.
- R7: The frame index counts boundaries modulo 192, starting at 0 after reset. Block start is high exactly while the index is 0 to 15.
- R8: A sample pair strobed in is held pending and becomes active only at the next frame boundary. A frame never mixes two pairs. If no new pair arrives, the last pair repeats.
- R9: With the audio group disabled, frame-sync and serial data are held low.
- R10: The auxiliary group gives a half-frame clock (low in the first half of the frame, high in the second) and block start. It also gives the status, user and validity bits of the channel of the current half: left when low, right when high. With the group disabled, all five outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| smp_valid | input | 1 | New sample pair strobe |
| smp_left | input | 24 | Left audio sample |
| smp_right | input | 24 | Right audio sample |
| smp_cs_l | input | 1 | Left channel-status bit |
| smp_cs_r | input | 1 | Right channel-status bit |
| smp_ud_l | input | 1 | Left user-data bit |
| smp_ud_r | input | 1 | Right user-data bit |
| smp_vb_l | input | 1 | Left validity bit |
| smp_vb_r | input | 1 | Right validity bit |
| g1_fs_o | output | 1 | Frame sync (TDM) or word select (I2S) |
| g1_sd_o | output | 1 | Serial data |
| g2_lr_o | output | 1 | Half-frame clock for auxiliary bits |
| g2_blk_o | output | 1 | Block-start flag |
| g2_cs_o | output | 1 | Channel status of current half |
| g2_ud_o | output | 1 | User data of current half |
| g2_vb_o | output | 1 | Validity of current half |

## Verification
The bench strobes a new sample pair in the middle of a frame. A design that latched it at once would send a right sample from a different pair than the left one, or a decoded word that does not match the audio. It runs more than 192 I2S frames to cross index 15→16 and the 191→0 wrap. An off-by-one counter would move or widen the block-start window. It writes reserved bits and writes the configuration mid-frame. A design that decoded the wrong bits, or failed to restart, would show the wrong format or a shifted frame-sync. The scoreboard also checks the exact bit position of every payload bit in both formats, which catches a missing one-clock delay in I2S or a reversed slot-1 bit order.

// File: rtl/aux_tdm_pkg.sv
package aux_tdm_pkg;

    // Active configuration bits; packed order matches write-data bits 2..0
    typedef struct packed {
        logic tdm;
        logic g2_en;
        logic g1_en;
    } cfg_t;

    // Per-pair auxiliary bits, ordered as they are packed after block start
    typedef struct packed {
        logic cs_r;
        logic cs_l;
        logic ud_r;
        logic ud_l;
        logic vb_r;
        logic vb_l;
    } aux_t;

    localparam int AUX_WORD_W = 7;

endpackage

// File: rtl/aux_tdm_timer.sv
module aux_tdm_timer #(
    parameter int SLOT_W     = 32,
    parameter int SLOTS      = 8,
    parameter int BLK_FRAMES = 192,
    localparam int CNT_W     = $clog2(SLOT_W * SLOTS),
    localparam int FIDX_W    = $clog2(BLK_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tdm,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [FIDX_W-1:0] fidx_o,
    output logic              bnd_o
);

    localparam logic [CNT_W-1:0]  TDM_LAST = CNT_W'(SLOT_W * SLOTS - 1);
    localparam logic [CNT_W-1:0]  I2S_LAST = CNT_W'(2 * SLOT_W - 1);
    localparam logic [FIDX_W-1:0] FIDX_MAX = FIDX_W'(BLK_FRAMES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FIDX_W-1:0] fidx;
    } tmr_t;

    tmr_t st_d, st_q;
    logic bnd;

    always_comb begin
        st_d = st_q;
        bnd  = restart || (st_q.cnt == (tdm ? TDM_LAST : I2S_LAST));
        if (bnd) begin
            st_d.cnt  = '0;
            st_d.fidx = (st_q.fidx == FIDX_MAX) ? '0 : st_q.fidx + 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign fidx_o = st_q.fidx;
    assign bnd_o  = bnd;

endmodule

// File: rtl/aux_tdm_slotmux.sv
module aux_tdm_slotmux
    import aux_tdm_pkg::*;
#(
    parameter int SMP_W  = 24,
    parameter int SLOT_W = 32,
    parameter int SLOTS  = 8,
    localparam int POS_W = $clog2(SLOT_W),
    localparam int SIDX_W = $clog2(SLOTS),
    localparam int CNT_W = POS_W + SIDX_W
) (
    input  logic                  tdm,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [SMP_W-1:0]      left,
    input  logic [SMP_W-1:0]      right,
    input  logic [AUX_WORD_W-1:0] auxw,
    output logic                  fs,
    output logic                  sd,
    output logic                  half
);

    localparam logic [SIDX_W-1:0] LEFT_SLOT  = SIDX_W'(0);
    localparam logic [SIDX_W-1:0] AUX_SLOT   = SIDX_W'(1);
    localparam logic [SIDX_W-1:0] RIGHT_SLOT = SIDX_W'(SLOTS / 2);
    localparam logic [POS_W-1:0]  SMP_LEN    = POS_W'(SMP_W);
    localparam logic [POS_W-1:0]  AUX_LEN    = POS_W'(AUX_WORD_W);

    logic [POS_W-1:0]      pos, pos_m1;
    logic [SIDX_W-1:0]     slot;
    logic [SMP_W-1:0]      l_sh, r_sh, i2s_sh, i2s_smp;
    logic [AUX_WORD_W-1:0] a_sh;

    always_comb begin
        pos     = cnt[POS_W-1:0];
        pos_m1  = pos - 1'b1;
        slot    = cnt[POS_W +: SIDX_W];
        half    = tdm ? cnt[CNT_W-1] : cnt[POS_W];
        l_sh    = left  << pos;
        r_sh    = right << pos;
        a_sh    = auxw  << pos;
        i2s_smp = cnt[POS_W] ? right : left;
        i2s_sh  = i2s_smp << pos_m1;
        sd      = 1'b0;
        if (tdm) begin
            fs = (cnt == '0);
            if (slot == LEFT_SLOT && pos < SMP_LEN)       sd = l_sh[SMP_W-1];
            else if (slot == RIGHT_SLOT && pos < SMP_LEN) sd = r_sh[SMP_W-1];
            else if (slot == AUX_SLOT && pos < AUX_LEN)   sd = a_sh[AUX_WORD_W-1];
        end else begin
            fs = cnt[POS_W];
            if (pos != '0 && pos <= SMP_LEN)              sd = i2s_sh[SMP_W-1];
        end
    end

endmodule

// File: rtl/aux_tdm_serializer.sv
module aux_tdm_serializer
    import aux_tdm_pkg::*;
#(
    parameter int SMP_W      = 24,
    parameter int SLOT_W     = 32,
    parameter int SLOTS      = 8,
    parameter int BLK_FRAMES = 192,
    parameter int BLK_HI     = 16,
    parameter int CFG_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             smp_cs_l,
    input  logic             smp_cs_r,
    input  logic             smp_ud_l,
    input  logic             smp_ud_r,
    input  logic             smp_vb_l,
    input  logic             smp_vb_r,
    output logic             g1_fs_o,
    output logic             g1_sd_o,
    output logic             g2_lr_o,
    output logic             g2_blk_o,
    output logic             g2_cs_o,
    output logic             g2_ud_o,
    output logic             g2_vb_o
);

    localparam int CNT_W  = $clog2(SLOT_W * SLOTS);
    localparam int FIDX_W = $clog2(BLK_FRAMES);
    localparam logic [FIDX_W-1:0] BLK_HI_V = FIDX_W'(BLK_HI);

    typedef struct packed {
        cfg_t             cfg;
        logic [SMP_W-1:0] pend_l;
        logic [SMP_W-1:0] pend_r;
        aux_t             pend_aux;
        logic [SMP_W-1:0] act_l;
        logic [SMP_W-1:0] act_r;
        aux_t             act_aux;
    } ser_t;

    ser_t st_d, st_q;

    logic [CNT_W-1:0]      cnt;
    logic [FIDX_W-1:0]     fidx;
    logic                  bnd, blk, fs, sd, half;
    logic [AUX_WORD_W-1:0] auxw;
    logic                  unused_resv;

    assign unused_resv = ^cfg_wdata[CFG_W-1:3];

    aux_tdm_timer #(
        .SLOT_W(SLOT_W), .SLOTS(SLOTS), .BLK_FRAMES(BLK_FRAMES)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(cfg_we), .tdm(st_q.cfg.tdm),
        .cnt_o(cnt), .fidx_o(fidx), .bnd_o(bnd)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = cfg_t'(cfg_wdata[2:0]);
        if (smp_valid) begin
            st_d.pend_l   = smp_left;
            st_d.pend_r   = smp_right;
            st_d.pend_aux = '{cs_r: smp_cs_r, cs_l: smp_cs_l, ud_r: smp_ud_r,
                              ud_l: smp_ud_l, vb_r: smp_vb_r, vb_l: smp_vb_l};
        end
        if (bnd) begin
            st_d.act_l   = st_q.pend_l;
            st_d.act_r   = st_q.pend_r;
            st_d.act_aux = st_q.pend_aux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk  = (fidx < BLK_HI_V);
    assign auxw = {blk, st_q.act_aux};

    aux_tdm_slotmux #(
        .SMP_W(SMP_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS)
    ) mux_i (
        .tdm(st_q.cfg.tdm), .cnt(cnt), .left(st_q.act_l), .right(st_q.act_r),
        .auxw(auxw), .fs(fs), .sd(sd), .half(half)
    );

    assign g1_fs_o  = st_q.cfg.g1_en & fs;
    assign g1_sd_o  = st_q.cfg.g1_en & sd;
    assign g2_lr_o  = st_q.cfg.g2_en & half;
    assign g2_blk_o = st_q.cfg.g2_en & blk;
    assign g2_cs_o  = st_q.cfg.g2_en & (half ? st_q.act_aux.cs_r : st_q.act_aux.cs_l);
    assign g2_ud_o  = st_q.cfg.g2_en & (half ? st_q.act_aux.ud_r : st_q.act_aux.ud_l);
    assign g2_vb_o  = st_q.cfg.g2_en & (half ? st_q.act_aux.vb_r : st_q.act_aux.vb_l);

endmodule

// File: rtl/aux_tdm_serializer_chk.sv
module aux_tdm_serializer_chk #(
    parameter int CNT_W  = 8,
    parameter int SMP_W  = 24,
    parameter int SLOT_W = 32,
    parameter int SLOTS  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_bits,
    input logic [CNT_W-1:0] cnt,
    input logic [SMP_W-1:0] act_l,
    input logic             g1_fs,
    input logic             g1_sd,
    input logic             g2_lr,
    input logic             g2_blk,
    input logic             g2_cs,
    input logic             g2_ud,
    input logic             g2_vb
);

    localparam logic [CNT_W-1:0] TDM_LAST = CNT_W'(SLOT_W * SLOTS - 1);
    localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(2 * SLOT_W - 1);
    localparam logic [CNT_W-1:0] S2_LO    = CNT_W'(2 * SLOT_W);
    localparam logic [CNT_W-1:0] S4_LO    = CNT_W'(4 * SLOT_W);

    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cnt == '0)); // R2

    AST_TDM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[2] && !cfg_we && cnt == TDM_LAST) |=> (cnt == '0)); // R3

    AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[2] && g1_fs && !cfg_we) |=> !g1_fs); // R3

    AST_UNUSED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[2] && cnt >= S2_LO && cnt < S4_LO) |-> !g1_sd); // R4

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cnt != (cfg_bits[2] ? TDM_LAST : I2S_LAST)) |=> $stable(act_l)); // R8

    AST_G1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[0] |-> (!g1_fs && !g1_sd)); // R9

    AST_G2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[1] |-> !(g2_lr || g2_blk || g2_cs || g2_ud || g2_vb)); // R10

endmodule

bind aux_tdm_serializer aux_tdm_serializer_chk #(
    .CNT_W(CNT_W), .SMP_W(SMP_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bits(st_q.cfg),
    .cnt(cnt), .act_l(st_q.act_l),
    .g1_fs(g1_fs_o), .g1_sd(g1_sd_o), .g2_lr(g2_lr_o), .g2_blk(g2_blk_o),
    .g2_cs(g2_cs_o), .g2_ud(g2_ud_o), .g2_vb(g2_vb_o)
);

// File: tb/aux_tdm_serializer_tb_top.sv
`timescale 1ns/1ps
module aux_tdm_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        smp_cs_l = 0, smp_cs_r = 0, smp_ud_l = 0, smp_ud_r = 0, smp_vb_l = 0, smp_vb_r = 0;
    logic        g1_fs_o, g1_sd_o, g2_lr_o, g2_blk_o, g2_cs_o, g2_ud_o, g2_vb_o;

    int checks = 0;
    int errors = 0;
    bit sb_on  = 0;

    always #4 clk = ~clk;

    aux_tdm_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .smp_cs_l(smp_cs_l), .smp_cs_r(smp_cs_r), .smp_ud_l(smp_ud_l),
        .smp_ud_r(smp_ud_r), .smp_vb_l(smp_vb_l), .smp_vb_r(smp_vb_r),
        .g1_fs_o(g1_fs_o), .g1_sd_o(g1_sd_o), .g2_lr_o(g2_lr_o),
        .g2_blk_o(g2_blk_o), .g2_cs_o(g2_cs_o), .g2_ud_o(g2_ud_o), .g2_vb_o(g2_vb_o)
    );

    // Reference model built from the requirements; aux order {cs_r,cs_l,ud_r,ud_l,vb_r,vb_l}
    logic [2:0]  m_cfg;
    int          m_cnt, m_f, m_last;
    logic [23:0] m_pl, m_pr, m_al, m_ar;
    logic [5:0]  m_pa, m_aa;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg <= '0; m_cnt <= 0; m_f <= 0;
            m_pl <= '0; m_pr <= '0; m_al <= '0; m_ar <= '0; m_pa <= '0; m_aa <= '0;
        end else begin
            m_last = m_cfg[2] ? 255 : 63;
            if (cfg_we) m_cfg <= cfg_wdata[2:0];
            if (smp_valid) begin
                m_pl <= smp_left; m_pr <= smp_right;
                m_pa <= {smp_cs_r, smp_cs_l, smp_ud_r, smp_ud_l, smp_vb_r, smp_vb_l};
            end
            if (cfg_we || m_cnt == m_last) begin
                m_cnt <= 0;
                m_f   <= (m_f == 191) ? 0 : m_f + 1;
                m_al <= m_pl; m_ar <= m_pr; m_aa <= m_pa;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (cnt %0d frame %0d)", tag, act, exp, m_cnt, m_f);
        end
    endtask

    // Per-cycle scoreboard, sampled on the falling edge
    always @(negedge clk) begin
        if (sb_on && rst_n) begin
            logic tdm, half, blk, sd_e, fs_e;
            logic [6:0] aw;
            int slot, b;
            tdm  = m_cfg[2];
            half = tdm ? (m_cnt >= 128) : (m_cnt >= 32);
            blk  = (m_f < 16);                               // R7
            aw   = {blk, m_aa};
            slot = m_cnt / 32;
            b    = m_cnt % 32;
            sd_e = 1'b0;
            if (tdm) begin
                fs_e = (m_cnt == 0);
                if (slot == 0 && b < 24)      sd_e = m_al[23-b];
                else if (slot == 4 && b < 24) sd_e = m_ar[23-b];
                else if (slot == 1 && b < 7)  sd_e = aw[6-b];
            end else begin
                fs_e = half;
                if (b >= 1 && b <= 24) sd_e = half ? m_ar[24-b] : m_al[24-b];
            end
            chk(tdm ? "R3 R9 frame sync" : "R6 R9 word select", g1_fs_o, m_cfg[0] & fs_e);
            chk(tdm ? "R4 R5 R8 R9 tdm data" : "R6 R8 R9 i2s data", g1_sd_o, m_cfg[0] & sd_e);
            chk("R10 half clock", g2_lr_o, m_cfg[1] & half);
            chk("R7 R10 block start", g2_blk_o, m_cfg[1] & blk);
            chk("R10 status", g2_cs_o, m_cfg[1] & (half ? m_aa[5] : m_aa[4]));
            chk("R10 user", g2_ud_o, m_cfg[1] & (half ? m_aa[3] : m_aa[2]));
            chk("R10 validity", g2_vb_o, m_cfg[1] & (half ? m_aa[1] : m_aa[0]));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_sample(input logic [23:0] l, input logic [23:0] r, input logic [5:0] a);
        smp_left = l; smp_right = r;
        {smp_cs_r, smp_cs_l, smp_ud_r, smp_ud_l, smp_vb_r, smp_vb_l} = a;
        smp_valid = 1'b1;
        cyc(1);
        smp_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [15:0] d);
        cfg_wdata = d; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    // {tdm, g2_en, g1_en, left, right, aux}
    localparam logic [56:0] VEC [6] = '{
        {1'b1, 2'b11, 24'hA5C3F1, 24'h5A3C0F, 6'b101010},
        {1'b1, 2'b11, 24'h800001, 24'h7FFFFE, 6'b010101},
        {1'b1, 2'b01, 24'hFFFFFF, 24'h000000, 6'b111111},
        {1'b1, 2'b10, 24'h123456, 24'h654321, 6'b110011},
        {1'b0, 2'b11, 24'hC0FFEE, 24'h0BEEF0, 6'b100101},
        {1'b0, 2'b11, 24'h000001, 24'h800000, 6'b011010}
    };

    initial begin
        cyc(3);
        // R1: outputs low while in reset
        chk("R1 reset fs", g1_fs_o, 1'b0);
        chk("R1 reset sd", g1_sd_o, 1'b0);
        chk("R1 reset aux", g2_lr_o | g2_blk_o | g2_cs_o | g2_ud_o | g2_vb_o, 1'b0);
        rst_n = 1'b1;
        sb_on = 1'b1;
        cyc(70);

        // R2: only reserved bits set -> everything stays off
        write_cfg(16'hFFF8);
        chk("R2 reserved ignored", g1_fs_o | g1_sd_o | g2_lr_o | g2_blk_o, 1'b0);
        cyc(20);

        // Table of vectors walked by one loop
        foreach (VEC[i]) begin
            put_sample(VEC[i][53:30], VEC[i][29:6], VEC[i][5:0]);
            write_cfg({13'h1FFF, VEC[i][56:54]});    // reserved bits set, R2
            cyc(300);
        end

        // R8: new pair strobed mid-frame must wait for the boundary
        put_sample(24'h111111, 24'h222222, 6'b000000);
        write_cfg(16'h0007);
        cyc(40);
        put_sample(24'hEEEEEE, 24'hDDDDDD, 6'b111111);
        cyc(600);

        // R2: mid-frame rewrite restarts the frame; R3 sync at next cycle
        cyc(77);
        write_cfg(16'h0007);
        chk("R2 R3 restart sync", g1_fs_o, 1'b1);
        cyc(300);

        // R7: run past index 15->16 and the 191->0 wrap in I2S
        put_sample(24'h5A5A5A, 24'hA5A5A5, 6'b100110);
        write_cfg(16'h0003);
        cyc(64 * 200);
        sb_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule